// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small memory-mapped mailbox that a host processor uses to hand short commands to a management controller. The host reaches it through a plain 32-bit register bus with a byte address, a write strobe, a read strobe and data. A single write to the command register stores a packed command word and rings the controller at once. Before that write the host fills a 16-byte outbound buffer. Once the command is finished it can read a 16-byte inbound buffer that the controller has filled.

The controller side receives a one-cycle doorbell together with the decoded opcode, sub-command and payload size. It reads the outbound buffer one byte at a time through a combinational port and writes the inbound buffer one word at a time. It ends each command by pulsing a done input, and it can report an error code at the same moment. The handshake rests on three status flags: busy, error and interrupt. A per-command flag decides whether completion also raises a one-cycle host interrupt.

No interface here carries back-pressure. A controller buffer write lands in the cycle it is strobed. A host access completes in the cycle it is strobed, and read data is combinational. The host is expected to poll busy, or to wait for the interrupt, before it reads results or issues the next command.

Top module: `hc_mailbox`

## Requirements
- R1: After reset the status word at offset 0x04 reads zero except the initiator id in bits 15:8 (parameter, default 0x5A). `host_irq` and `db_pulse` are low.
- R2: A host write to offset 0x00 while idle stores the command word. The word is packed as opcode in bits 7:0, interrupt-request flag in bit 8, sub-command in bits 15:12 and size in bits 23:16. In the following cycle `db_pulse` is high for exactly one cycle, the `db_*` fields show the stored word, and status bit 0 (busy) is set.
- R3: A command write that arrives while busy is set is ignored. No doorbell pulse is produced and the `db_*` fields keep their values. This also holds when the write coincides with `ctl_done`.
- R4: `ctl_done` while busy clears busy in the next cycle. `ctl_done` while idle has no effect on the status word or on `host_irq`.
- R5: When `ctl_err` is high with a honoured `ctl_done`, status bit 1 is set and `ctl_err_code` is loaded into status bits 23:16. Both the bit and the code are cleared when the next command is accepted.
- R6: If the stored command has bit 8 set, completion makes `host_irq` high for exactly one cycle and sets status bit 2. Without bit 8, neither happens. A host write to offset 0x04 with data bit 2 set clears status bit 2.
- R7: Status bits 7:4 echo the sub-command of the stored command and bit 3 reads zero.
- R8: Host word writes to offsets 0x80, 0x84, 0x88 and 0x8C fill the outbound buffer in little-endian order. Outbound byte n, on `ctl_wb_data` for `ctl_wb_addr`=n, is bits 8*(n%4)+7 : 8*(n%4) of the word at 0x80+4*(n/4). Host reads of 0x00 and of 0x80–0x8F return zero.
- R9: A controller write (`ctl_rb_we`) of word w is visible to host word reads at 0x90+4*w. A host read with `host_rd_byte` high at 0x90+n returns inbound byte n in bits 7:0 with the upper bits zero. Host writes to 0x90–0x9F are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rd_byte | input | 1 | Host read returns a single byte (inbound buffer only) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational, zero when not reading |
| host_irq | output | 1 | One-cycle completion interrupt |
| db_pulse | output | 1 | One-cycle doorbell to the controller |
| db_opcode | output | 8 | Stored opcode |
| db_subid | output | 4 | Stored sub-command |
| db_size | output | 8 | Stored payload size |
| ctl_wb_addr | input | 4 | Outbound buffer byte index |
| ctl_wb_data | output | 8 | Outbound buffer byte |
| ctl_rb_we | input | 1 | Inbound buffer word write strobe |
| ctl_rb_addr | input | 2 | Inbound buffer word index |
| ctl_rb_wdata | input | 32 | Inbound buffer word data |
| ctl_done | input | 1 | Command completion strobe |
| ctl_err | input | 1 | Completion carries an error |
| ctl_err_code | input | 8 | Error code loaded with an error |

## Verification
The hardest case to reach from the ports is a host command write landing in the same cycle as a controller completion. Busy is still set in that cycle, so the write has to be dropped even though the block is idle one cycle later. A dedicated task raises `host_wr` to offset 0x00 and `ctl_done` between the same pair of edges. It then checks that no doorbell appears, that the `db_*` fields are unchanged, and that busy reads clear. Clearing the interrupt flag by writing status is also exercised after an interrupting completion. A check then confirms that the flag stays clear.

// File: rtl/mb_pkg.sv
package mb_pkg;
  localparam int HOST_AW = 8;
  localparam int HOST_DW = 32;

  localparam logic [HOST_AW-1:0] OFS_CMD  = 8'h00;
  localparam logic [HOST_AW-1:0] OFS_STAT = 8'h04;
  localparam logic [3:0]         PAGE_WB  = 4'h8;
  localparam logic [3:0]         PAGE_RB  = 4'h9;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_ERR_BIT  = 1;
  localparam int STAT_IRQ_BIT  = 2;

  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] size;
    logic [3:0] sub;
    logic [2:0] rsv_lo;
    logic       want_irq;
    logic [7:0] opcode;
  } cmd_word_t;
endpackage

// File: rtl/mb_buffer.sv
module mb_buffer #(
  parameter int NBYTES = 16,
  parameter int WORD_B = 4,
  localparam int NWORDS = NBYTES / WORD_B,
  localparam int WIDX_W = $clog2(NWORDS),
  localparam int BIDX_W = $clog2(NBYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [WIDX_W-1:0]     wr_idx,
  input  logic [8*WORD_B-1:0]   wr_data,
  input  logic [WIDX_W-1:0]     rd_widx,
  output logic [8*WORD_B-1:0]   rd_word,
  input  logic [BIDX_W-1:0]     rd_bidx,
  output logic [7:0]            rd_byte
);
  logic [7:0] mem [NBYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < WORD_B; b++)
        mem[int'(wr_idx)*WORD_B + b] <= wr_data[8*b +: 8];
    end
  end

  genvar g;
  generate
    for (g = 0; g < WORD_B; g++) begin : g_lane
      assign rd_word[8*g +: 8] = mem[int'(rd_widx)*WORD_B + g];
    end
  endgenerate

  assign rd_byte = mem[rd_bidx];
endmodule

// File: rtl/mb_cmd_ctrl.sv
module mb_cmd_ctrl
  import mb_pkg::*;
#(
  parameter int ECODE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [HOST_DW-1:0] cmd_wdata,
  input  logic               stat_wr,
  input  logic               stat_clr_irq,
  input  logic               done,
  input  logic               done_err,
  input  logic [ECODE_W-1:0] done_code,
  output cmd_word_t          cmd_q,
  output logic               busy,
  output logic               err_flag,
  output logic [ECODE_W-1:0] err_code,
  output logic               irq_flag,
  output logic               irq_pulse,
  output logic               bell
);
  logic accept;
  logic finish;

  assign accept = cmd_wr && !busy;
  assign finish = done && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      busy      <= 1'b0;
      err_flag  <= 1'b0;
      err_code  <= '0;
      irq_flag  <= 1'b0;
      irq_pulse <= 1'b0;
      bell      <= 1'b0;
    end else begin
      bell      <= accept;
      irq_pulse <= finish && cmd_q.want_irq;
      if (accept) begin
        cmd_q    <= cmd_word_t'(cmd_wdata);
        busy     <= 1'b1;
        err_flag <= 1'b0;
        err_code <= '0;
      end else if (finish) begin
        busy     <= 1'b0;
        err_flag <= done_err;
        err_code <= done_err ? done_code : '0;
      end
      if (finish && cmd_q.want_irq) irq_flag <= 1'b1;
      else if (stat_wr && stat_clr_irq) irq_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/hc_mailbox.sv
module hc_mailbox
  import mb_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter logic [7:0] INITIATOR_ID = 8'h5A,
  localparam int WIDX_W = $clog2(BUF_BYTES / 4),
  localparam int BIDX_W = $clog2(BUF_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic               host_rd_byte,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               host_irq,
  output logic               db_pulse,
  output logic [7:0]         db_opcode,
  output logic [3:0]         db_subid,
  output logic [7:0]         db_size,
  input  logic [BIDX_W-1:0]  ctl_wb_addr,
  output logic [7:0]         ctl_wb_data,
  input  logic               ctl_rb_we,
  input  logic [WIDX_W-1:0]  ctl_rb_addr,
  input  logic [HOST_DW-1:0] ctl_rb_wdata,
  input  logic               ctl_done,
  input  logic               ctl_err,
  input  logic [7:0]         ctl_err_code
);
  logic hit_cmd, hit_stat, hit_wb, hit_rb;
  logic cmd_wr, stat_wr, wb_wr;
  cmd_word_t cmd_q;
  logic busy, err_flag, irq_flag;
  logic [7:0] err_code;
  logic [HOST_DW-1:0] wb_word_unused, rb_word, status_word;
  logic [7:0] rb_byte, wb_byte_unused;

  assign hit_cmd  = (host_addr == OFS_CMD);
  assign hit_stat = (host_addr == OFS_STAT);
  assign hit_wb   = (host_addr[7:4] == PAGE_WB);
  assign hit_rb   = (host_addr[7:4] == PAGE_RB);

  assign cmd_wr  = host_wr && hit_cmd;
  assign stat_wr = host_wr && hit_stat;
  assign wb_wr   = host_wr && hit_wb;

  mb_cmd_ctrl #(.ECODE_W(8)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_wdata(host_wdata),
    .stat_wr(stat_wr), .stat_clr_irq(host_wdata[STAT_IRQ_BIT]),
    .done(ctl_done), .done_err(ctl_err), .done_code(ctl_err_code),
    .cmd_q(cmd_q), .busy(busy), .err_flag(err_flag), .err_code(err_code),
    .irq_flag(irq_flag), .irq_pulse(host_irq), .bell(db_pulse)
  );

  mb_buffer #(.NBYTES(BUF_BYTES)) u_outbound (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wb_wr), .wr_idx(host_addr[2 +: WIDX_W]), .wr_data(host_wdata),
    .rd_widx('0), .rd_word(wb_word_unused),
    .rd_bidx(ctl_wb_addr), .rd_byte(ctl_wb_data)
  );

  mb_buffer #(.NBYTES(BUF_BYTES)) u_inbound (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ctl_rb_we), .wr_idx(ctl_rb_addr), .wr_data(ctl_rb_wdata),
    .rd_widx(host_addr[2 +: WIDX_W]), .rd_word(rb_word),
    .rd_bidx(host_addr[BIDX_W-1:0]), .rd_byte(rb_byte)
  );

  assign wb_byte_unused = '0;

  always_comb begin
    status_word = '0;
    status_word[STAT_BUSY_BIT] = busy;
    status_word[STAT_ERR_BIT]  = err_flag;
    status_word[STAT_IRQ_BIT]  = irq_flag;
    status_word[7:4]   = cmd_q.sub;
    status_word[15:8]  = INITIATOR_ID;
    status_word[23:16] = err_code;
  end

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      if (hit_stat)      host_rdata = status_word;
      else if (hit_rb)   host_rdata = host_rd_byte ? {24'h0, rb_byte} : rb_word;
    end
  end

  assign db_opcode = cmd_q.opcode;
  assign db_subid  = cmd_q.sub;
  assign db_size   = cmd_q.size;
endmodule

// File: rtl/mb_checker.sv
module mb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic       busy,
  input logic       err_flag,
  input logic       ctl_done,
  input logic       db_pulse,
  input logic [7:0] db_opcode,
  input logic       host_irq
);
  a_r2_bell_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    db_pulse |=> !db_pulse);
  a_r2_bell_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    db_pulse |-> busy);
  a_r3_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> (!db_pulse && $stable(db_opcode)));
  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_done) |=> !busy);
  a_r5_err_cleared_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    db_pulse |-> !err_flag);
  a_r6_irq_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (!busy && $past(ctl_done)));
endmodule

bind hc_mailbox mb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .busy(busy),
  .err_flag(err_flag), .ctl_done(ctl_done), .db_pulse(db_pulse),
  .db_opcode(db_opcode), .host_irq(host_irq)
);

// File: tb/hc_mailbox_bench.sv
module hc_mailbox_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0, host_rd_byte = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic host_irq, db_pulse;
  logic [7:0] db_opcode, db_size;
  logic [3:0] db_subid;
  logic [3:0] ctl_wb_addr = '0;
  logic [7:0] ctl_wb_data;
  logic ctl_rb_we = 1'b0;
  logic [1:0] ctl_rb_addr = '0;
  logic [31:0] ctl_rb_wdata = '0;
  logic ctl_done = 1'b0, ctl_err = 1'b0;
  logic [7:0] ctl_err_code = '0;

  int n_chk = 0, n_fail = 0;
  localparam logic [31:0] IDW = 32'h0000_5A00;

  always #2 clk = ~clk;

  hc_mailbox u_hc_mailbox (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic byte_mode, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1; host_rd_byte = byte_mode;
    #1 d = host_rdata;
    host_rd = 1'b0; host_rd_byte = 1'b0;
  endtask

  task automatic finish_cmd(input logic e, input logic [7:0] code);
    @(negedge clk);
    ctl_done = 1'b1; ctl_err = e; ctl_err_code = code;
    @(posedge clk);
    @(negedge clk);
    ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(8'h04, 1'b0, d);
    check("R1 status", d, IDW);
    check("R1 irq", {31'b0, host_irq}, 0);
    check("R1 bell", {31'b0, db_pulse}, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    bus_wr(8'h00, 32'h0005_30A7);
    check("R2 bell", {31'b0, db_pulse}, 1);
    check("R2 fields", {12'b0, db_size, db_subid, db_opcode}, {12'b0, 8'h05, 4'h3, 8'hA7});
    @(negedge clk);
    check("R2 bell single", {31'b0, db_pulse}, 0);
    bus_rd(8'h04, 1'b0, d);
    check("R2 R7 status busy", d, IDW | 32'h31);
    bus_rd(8'h00, 1'b0, d);
    check("R8 cmd reads zero", d, 0);
    finish_cmd(1'b0, 8'h00);
    check("R6 no irq without flag", {31'b0, host_irq}, 0);
    bus_rd(8'h04, 1'b0, d);
    check("R4 R6 status idle", d, IDW | 32'h30);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    bus_wr(8'h00, 32'h0000_2011);
    bus_wr(8'h00, 32'h0000_40EE);
    check("R3 no bell while busy", {31'b0, db_pulse}, 0);
    check("R3 opcode kept", {24'b0, db_opcode}, 32'h11);
    @(negedge clk);
    host_addr = 8'h00; host_wdata = 32'h0000_50CC; host_wr = 1'b1; ctl_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0; ctl_done = 1'b0;
    check("R3 collide no bell", {31'b0, db_pulse}, 0);
    check("R3 collide opcode", {24'b0, db_opcode}, 32'h11);
    bus_rd(8'h04, 1'b0, d);
    check("R3 R4 idle after collide", d, IDW | 32'h20);
  endtask

  task automatic t_done_idle();
    logic [31:0] d;
    finish_cmd(1'b1, 8'h77);
    check("R4 idle done no irq", {31'b0, host_irq}, 0);
    bus_rd(8'h04, 1'b0, d);
    check("R4 idle done status", d, IDW | 32'h20);
  endtask

  task automatic t_error();
    logic [31:0] d;
    bus_wr(8'h00, 32'h0000_1042);
    finish_cmd(1'b1, 8'hC3);
    bus_rd(8'h04, 1'b0, d);
    check("R5 error set", d, IDW | 32'h00C3_0012);
    bus_wr(8'h00, 32'h0000_2043);
    bus_rd(8'h04, 1'b0, d);
    check("R5 error cleared", d, IDW | 32'h21);
    finish_cmd(1'b0, 8'h00);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    bus_wr(8'h00, 32'h0000_6155);
    finish_cmd(1'b0, 8'h00);
    check("R6 irq pulse", {31'b0, host_irq}, 1);
    @(negedge clk);
    check("R6 irq single", {31'b0, host_irq}, 0);
    bus_rd(8'h04, 1'b0, d);
    check("R6 flag set", d, IDW | 32'h64);
    bus_wr(8'h04, 32'h0000_0004);
    bus_rd(8'h04, 1'b0, d);
    check("R6 flag cleared", d, IDW | 32'h60);
  endtask

  task automatic t_wbuf();
    logic [31:0] d;
    for (int w = 0; w < 4; w++)
      bus_wr(8'h80 + 8'(4*w), 32'h1000_0000 * (w+1) + 32'h0403_0201 + 32'h0101_0101 * (4*w));
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      ctl_wb_addr = 4'(n);
      #1;
      if ((n % 4) != 3) check("R8 outbound byte", {24'b0, ctl_wb_data}, 32'(n + 1));
      else check("R8 outbound top byte", {24'b0, ctl_wb_data}, 32'(n + 1 + 16*(n/4+1)));
    end
    bus_rd(8'h84, 1'b0, d);
    check("R8 outbound reads zero", d, 0);
  endtask

  task automatic t_rbuf();
    logic [31:0] d;
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      ctl_rb_we = 1'b1; ctl_rb_addr = 2'(w); ctl_rb_wdata = 32'hA0B0_C0D0 + 32'(w);
      @(posedge clk);
      @(negedge clk);
      ctl_rb_we = 1'b0;
    end
    bus_rd(8'h98, 1'b0, d);
    check("R9 inbound word", d, 32'hA0B0_C0D2);
    bus_rd(8'h9C, 1'b1, d);
    check("R9 inbound byte 12", d, 32'hD3);
    bus_rd(8'h95, 1'b1, d);
    check("R9 inbound byte 5", d, 32'hC0);
    bus_wr(8'h90, 32'hDEAD_BEEF);
    bus_rd(8'h90, 1'b0, d);
    check("R9 host write ignored", d, 32'hA0B0_C0D0);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_busy_ignore();
    t_done_idle();
    t_error();
    t_irq();
    t_wbuf();
    t_rbuf();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule